// File: doc/BRIEF.md
# Target Data-Width Response Unit

This unit sits on the target side of a parallel shared bus that has an optional upper 32-bit data half. When a master opens a transaction it may ask for the wide path. At the address phase the unit checks that request, the command and the capability of the addressed region. It then commits to one of three answers. It can take the transfer on both halves, finish the burst on the lower half only, or end the transaction after a single lower-half transfer.

All bus controls are abstracted to active-high levels. `frame` marks a master-owned transaction, `irdy` marks master data ready, `devsel` claims the transaction, `ack64` grants the wide path, `trdy` marks target data ready and `stop` asks the master to end. The local backend reports `backend_busy`, and while it is high the unit ends the transaction without moving data. For each completed data phase the unit reports which halves moved and which byte lanes were written.

Top module: `tgt_width_resp`

## Requirements
- R1: While reset is held and right after it is released, `devsel`, `ack64`, `trdy`, `stop`, `xfer_lo`, `xfer_hi` and `lane_be` are all low.
- R2: An address phase is a clock in which `frame` is high and the unit is idle. If `addr_hit` is high there, `devsel` is high from the next clock until the first clock in which `frame` and `irdy` are both low. If `addr_hit` is low, the unit drives nothing until the bus goes idle.
- R3: `ack64` rises only when, at the address phase, `req64` was high, `region_wide` was high and `cmd` was a memory command. The memory command codes are 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111.
- R4: `ack64` is only ever high together with `devsel`. It is decided once per transaction and holds its value for as long as `devsel` stays high.
- R5: Any other command never receives `ack64`, whatever `req64` is. This includes interrupt acknowledge 4'b0000, special cycle 4'b0001, I/O 4'b0010/4'b0011 and configuration 4'b1010/4'b1011.
- R6: In a wide transaction, every completed data phase raises `xfer_lo` and `xfer_hi`, and `lane_be` equals all 8 bits of `be`. This holds for any byte-enable pattern, including one that changes every phase.
- R7: In a narrow transaction, `xfer_hi` stays low and `lane_be[7:4]` is zero. `lane_be[3:0]` copies `be[3:0]` on completed phases.
- R8: If `burst_ok` was low at the address phase, the first data phase shows `trdy` and `stop` together. Once a transfer completes, `stop` stays high and `trdy` stays low until the bus goes idle.
- R9: While the backend is busy during a data phase, the unit shows `stop` without `trdy`. This is a retry on the first phase and a disconnect later. `stop` then stays high and `trdy` low until the bus goes idle.
- R10: A data phase with `be` all zero and the backend not busy is completed with `trdy`. It never causes `stop`.
- R11: `xfer_lo` is high exactly in the clocks where the unit is in a data phase with `irdy` and `trdy` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame | input | 1 | Master holds a transaction open |
| irdy | input | 1 | Master data ready |
| req64 | input | 1 | Master asks for the wide path |
| cmd | input | 4 | Bus command, valid at the address phase |
| addr_hit | input | 1 | Address decodes to this target |
| region_wide | input | 1 | Addressed region supports the wide path |
| burst_ok | input | 1 | Addressed region can sustain a burst |
| backend_busy | input | 1 | Local backend cannot take or give data |
| be | input | 8 | Byte enables of the current data phase |
| devsel | output | 1 | Transaction claimed |
| ack64 | output | 1 | Wide path granted |
| trdy | output | 1 | Target data ready |
| stop | output | 1 | Target asks to end the transaction |
| xfer_lo | output | 1 | Lower half moved this clock |
| xfer_hi | output | 1 | Upper half moved this clock |
| lane_be | output | 8 | Byte lanes moved this clock |

## Verification
The width decision and the single-transfer decision are latched. If either is wrong, the error shows at the ports one clock after the address phase, through `ack64` or through the `stop` of the first data phase. If the phase state is wrong, `devsel` may outlive the idle bus, or `stop` may drop after it rose. `trdy` may also go missing on a phase with no byte enables. Each of these shows in the same clock the master drives the phase. The bench follows its own model clock by clock, so any such mismatch is caught at the first cycle it appears.

// File: rtl/tw_pkg.sv
package tw_pkg;
  parameter int CMD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_HOLD = 2'd2,
    ST_SKIP = 2'd3
  } tw_state_e;

  function automatic logic is_mem_cmd(input logic [CMD_W-1:0] c);
    case (c)
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: is_mem_cmd = 1'b1;
      default:                                     is_mem_cmd = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
(
  input  logic             req64,
  input  logic [CMD_W-1:0] cmd,
  input  logic             region_wide,
  input  logic             burst_ok,
  output logic             want_wide,
  output logic             want_single
);
  always_comb begin
    want_wide   = req64 && region_wide && is_mem_cmd(cmd);
    want_single = !burst_ok;
  end
endmodule

// File: rtl/tw_phase_fsm.sv
module tw_phase_fsm
  import tw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic irdy,
  input  logic addr_hit,
  input  logic want_wide,
  input  logic want_single,
  input  logic busy,
  output logic devsel,
  output logic ack64,
  output logic trdy,
  output logic stop
);
  tw_state_e st_q, st_d;
  logic wide_q, wide_d, single_q, single_d;
  logic addr_phase, bus_idle, in_data;

  // outputs and next state
  always_comb begin
    addr_phase = (st_q == ST_IDLE) && frame;
    bus_idle   = !frame && !irdy;
    in_data    = (st_q == ST_DATA);
    devsel     = in_data || (st_q == ST_HOLD);
    ack64      = devsel && wide_q;
    trdy       = in_data && !busy;
    stop       = (st_q == ST_HOLD) || (in_data && (busy || single_q));

    wide_d   = wide_q;
    single_d = single_q;
    if (addr_phase) begin
      wide_d   = want_wide;
      single_d = want_single;
    end else if (bus_idle) begin
      wide_d   = 1'b0;
      single_d = 1'b0;
    end

    st_d = st_q;
    case (st_q)
      ST_IDLE: if (frame) st_d = addr_hit ? ST_DATA : ST_SKIP;
      ST_DATA: begin
        if (bus_idle)                    st_d = ST_IDLE;
        else if (stop && (busy || irdy)) st_d = ST_HOLD;
      end
      ST_HOLD: if (bus_idle) st_d = ST_IDLE;
      ST_SKIP: if (bus_idle) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wide_q   <= 1'b0;
      single_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      wide_q   <= wide_d;
      single_q <= single_d;
    end
  end

  assert_ack_needs_devsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack64 |-> devsel);

  assert_ack_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel && $past(devsel)) |-> (ack64 == $past(ack64)));

  assert_idle_completes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !busy) |-> trdy);

  assert_retry_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && stop && !trdy) |-> busy);
endmodule

// File: rtl/tw_lane.sv
module tw_lane #(
  parameter int BE_W = 8
) (
  input  logic            irdy,
  input  logic            trdy,
  input  logic            ack64,
  input  logic [BE_W-1:0] be,
  output logic            xfer_lo,
  output logic            xfer_hi,
  output logic [BE_W-1:0] lane_be
);
  localparam int HALF = BE_W / 2;

  logic moved;
  assign moved   = irdy && trdy;
  assign xfer_lo = moved;
  assign xfer_hi = moved && ack64;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic half_en;
    if (h == 0) begin : g_low
      assign half_en = moved;
    end else begin : g_high
      assign half_en = moved && ack64;
    end
    assign lane_be[h*HALF +: HALF] = half_en ? be[h*HALF +: HALF] : '0;
  end
endmodule

// File: rtl/tgt_width_resp.sv
module tgt_width_resp
  import tw_pkg::*;
#(
  parameter int BE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic             irdy,
  input  logic             req64,
  input  logic [CMD_W-1:0] cmd,
  input  logic             addr_hit,
  input  logic             region_wide,
  input  logic             burst_ok,
  input  logic             backend_busy,
  input  logic [BE_W-1:0]  be,
  output logic             devsel,
  output logic             ack64,
  output logic             trdy,
  output logic             stop,
  output logic             xfer_lo,
  output logic             xfer_hi,
  output logic [BE_W-1:0]  lane_be
);
  localparam int HALF = BE_W / 2;

  logic rst_sync_n, want_wide, want_single;

  tw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tw_decode u_dec (
    .req64(req64), .cmd(cmd), .region_wide(region_wide), .burst_ok(burst_ok),
    .want_wide(want_wide), .want_single(want_single)
  );

  tw_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .frame(frame), .irdy(irdy),
    .addr_hit(addr_hit), .want_wide(want_wide), .want_single(want_single),
    .busy(backend_busy), .devsel(devsel), .ack64(ack64), .trdy(trdy), .stop(stop)
  );

  tw_lane #(.BE_W(BE_W)) u_lane (
    .irdy(irdy), .trdy(trdy), .ack64(ack64), .be(be),
    .xfer_lo(xfer_lo), .xfer_hi(xfer_hi), .lane_be(lane_be)
  );

  assert_ack_gated_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ack64) |-> $past(frame && req64 && region_wide && addr_hit && is_mem_cmd(cmd)));

  assert_hi_lanes_wide_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_hi || (lane_be[BE_W-1:HALF] != '0)) |-> ack64);

  assert_full_lanes_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_lo && ack64) |-> (lane_be == be));

  assert_stop_held_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (devsel && $past(devsel) && $past(stop)) |-> stop);
endmodule

// File: tb/test_tgt_width_resp.sv
module test_tgt_width_resp;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame = 0, irdy = 0, req64 = 0, addr_hit = 0, region_wide = 0;
  logic burst_ok = 0, backend_busy = 0;
  logic [3:0] cmd = 4'h0;
  logic [7:0] be = 8'h00;
  logic devsel, ack64, trdy, stop, xfer_lo, xfer_hi;
  logic [7:0] lane_be;

  int total = 0, bad = 0, cyc = 0;

  tgt_width_resp i_tgt_width_resp (
    .clk(clk), .rst_n(rst_n), .frame(frame), .irdy(irdy), .req64(req64),
    .cmd(cmd), .addr_hit(addr_hit), .region_wide(region_wide),
    .burst_ok(burst_ok), .backend_busy(backend_busy), .be(be),
    .devsel(devsel), .ack64(ack64), .trdy(trdy), .stop(stop),
    .xfer_lo(xfer_lo), .xfer_hi(xfer_hi), .lane_be(lane_be)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: 0 idle, 1 data, 2 stopping, 3 not ours
  int  ms = 0;
  bit  m_wide = 0, m_single = 0;
  logic m_devsel, m_ack, m_trdy, m_stop, m_xlo, m_xhi;
  logic [7:0] m_lane;

  function automatic bit mem_code(input logic [3:0] c);
    return (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
  endfunction

  always_comb begin
    m_devsel = (ms == 1) || (ms == 2);
    m_ack    = m_devsel && m_wide;
    m_trdy   = (ms == 1) && !backend_busy;
    m_stop   = (ms == 2) || ((ms == 1) && (backend_busy || m_single));
    m_xlo    = (ms == 1) && irdy && m_trdy;
    m_xhi    = m_xlo && m_wide;
    m_lane   = 8'h00;
    if (m_xlo) m_lane = m_wide ? be : {4'h0, be[3:0]};
  end

  always @(posedge clk) begin
    if (rst_n) begin
      case (ms)
        0: if (frame) begin
             ms       = addr_hit ? 1 : 3;
             m_wide   = addr_hit && req64 && region_wide && mem_code(cmd);
             m_single = !burst_ok;
           end
        1: if (!frame && !irdy) ms = 0;
           else if (m_stop && (backend_busy || irdy)) ms = 2;
        default: if (!frame && !irdy) ms = 0;
      endcase
      if (ms == 0) begin m_wide = 0; m_single = 0; end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, got, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R2 devsel", {7'b0, devsel}, {7'b0, m_devsel});
      check("R3 R4 R5 ack64", {7'b0, ack64}, {7'b0, m_ack});
      check("R8 R9 R10 trdy", {7'b0, trdy}, {7'b0, m_trdy});
      check("R8 R9 stop", {7'b0, stop}, {7'b0, m_stop});
      check("R11 xfer_lo", {7'b0, xfer_lo}, {7'b0, m_xlo});
      check("R6 R7 xfer_hi", {7'b0, xfer_hi}, {7'b0, m_xhi});
      check("R6 R7 lane_be", lane_be, m_lane);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] be_pat(input int ph);
    case (ph % 4)
      0: return 8'hF0;
      1: return 8'h00;
      2: return 8'h0F;
      default: return 8'h5A;
    endcase
  endfunction

  task automatic txn(input logic r64, input logic [3:0] c, input logic hit,
                     input logic wide, input logic burst, input int n, input int busy_at);
    int left = n; int ph = 0; int tries = 0; bit stopped = 0;
    logic t_s, s_s;
    @(negedge clk);
    frame = 1; irdy = 0; req64 = r64; cmd = c; addr_hit = hit;
    region_wide = wide; burst_ok = burst; be = 8'h00; backend_busy = 0;
    while (left > 0 && !stopped && tries < 6) begin
      @(negedge clk);
      req64 = 0; cmd = 4'h0; addr_hit = 0; region_wide = 0; burst_ok = 0;
      irdy = 1; frame = (left > 1); be = be_pat(ph);
      backend_busy = (tries == busy_at);
      #1; t_s = trdy; s_s = stop;
      @(posedge clk);
      if (t_s) begin left--; ph++; end
      if (s_s) stopped = 1;
      tries++;
    end
    if (frame) begin
      @(negedge clk); frame = 0; irdy = 1; backend_busy = 0;
    end
    @(negedge clk); frame = 0; irdy = 0; backend_busy = 0; be = 8'h00;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #2;
    // R1: quiet after reset
    check("R1 devsel", {7'b0, devsel}, 8'h00);
    check("R1 ack64", {7'b0, ack64}, 8'h00);
    check("R1 trdy/stop", {6'b0, trdy, stop}, 8'h00);
    check("R1 lanes", {xfer_lo, xfer_hi, 6'b0} | lane_be, 8'h00);

    txn(1, 4'h6, 1, 1, 1, 4, -1);   // R6 wide read with zero-BE phase
    txn(1, 4'h7, 1, 0, 1, 3, -1);   // R7 region narrow
    txn(0, 4'hC, 1, 1, 1, 3, -1);   // R3 no wide request
    txn(1, 4'h0, 1, 1, 1, 2, -1);   // R5 interrupt acknowledge
    txn(1, 4'h1, 1, 1, 1, 2, -1);   // R5 special cycle
    txn(1, 4'h2, 1, 1, 1, 2, -1);   // R5 I/O
    txn(1, 4'hB, 1, 1, 1, 2, -1);   // R5 configuration
    txn(1, 4'hF, 1, 0, 0, 4, -1);   // R8 single then disconnect
    txn(1, 4'hE, 1, 1, 0, 3, -1);   // R8 wide single
    txn(1, 4'h6, 1, 1, 1, 3, 0);    // R9 retry on first phase
    txn(0, 4'h7, 1, 0, 1, 4, 2);    // R9 disconnect mid burst
    txn(1, 4'h6, 0, 1, 1, 2, -1);   // R2 not addressed
    txn(0, 4'h6, 1, 0, 1, 2, -1);   // R10 zero BE in narrow mode
    txn(1, 4'h7, 1, 1, 1, 5, -1);   // R6 R11 longer wide burst
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule